// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block sits between instruction issue and the architectural state of an out-of-order core. At issue, each instruction takes a slot in a circular queue. The slot records what kind of instruction it is (register write, store or branch), its destination register and, for a branch, the predicted direction. The slot index goes back to the issue logic as the instruction's tag. Functional units finish in any order and report through the completion port, which writes the result into the tagged slot and marks it ready. Only the oldest slot, the head, may retire, and at most one slot retires per cycle. A register write goes to the register file. A store sends its address and data to memory. A branch compares its predicted direction with the resolved one.

A mispredicted branch or a faulting instruction is acted on only when it reaches the head. A mispredicted branch retires and raises a redirect carrying the resolved target, and every slot younger than it is discarded. A faulting instruction raises an exception strobe, writes nothing, and is discarded together with everything younger. In both cases the next slot handed out is the one just after the offending slot.

The allocate interface is valid/ready. A slot is taken only in a cycle where both `alloc_valid` and `alloc_ready` are high, and `alloc_idx` names it in that same cycle. `alloc_ready` drops while all slots are held and during a cycle in which the head flushes. Completion, lookup and the retire strobes are plain signals with no back-pressure. The issue logic may read a finished but unretired result through the combinational lookup port.

Top module: `rob_commit_queue`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready` is 1, `alloc_idx` is 0, `lookup_hit` is 0, and `rf_we`, `mem_we`, `redirect_valid` and `excp_valid` are all 0.
- R2: Accepted allocations receive consecutive indices modulo DEPTH. Once DEPTH slots are held, `alloc_ready` is 0.
- R3: A completion writes value, address, taken and fault into a held slot and marks it ready. A completion aimed at a slot that is not held has no effect: when that slot is later allocated, it is not ready.
- R4: Slots retire strictly in allocation order, one per cycle, and only when the head is ready. A ready younger slot waits behind an unready head.
- R5: A ready register-write head (kind code 0) drives `rf_we` for one cycle, with `rf_waddr` set to its destination and `rf_wdata` set to its value, starting the cycle after its completion.
- R6: A ready store head (kind code 1) drives `mem_we` for one cycle, with `mem_addr` set to the completion address and `mem_wdata` set to the completion value. It does not write the register file.
- R7: A branch head (kind code 2) whose resolved direction matches the prediction retires with no write and no redirect, and the slots behind it still retire.
- R8: A branch head whose direction differs from the prediction drives `redirect_valid` with `redirect_pc` set to its completion address. All younger slots are discarded and never retire. The next allocation index is the branch index plus one.
- R9: A head whose completion flagged a fault drives `excp_valid`, writes nothing, and is discarded with all younger slots. The next allocation index is its own index plus one.
- R10: `lookup_hit` is 1 exactly when the slot at `lookup_idx` is held and ready, and `lookup_value` then returns its value.
- R11: An allocation and a retirement in the same cycle leave the number of held slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue offers an instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_kind | input | 2 | 0 register write, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination register number |
| alloc_pred_taken | input | 1 | Predicted branch direction |
| alloc_idx | output | IDX_W | Slot given to the offered instruction |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | IDX_W | Slot being completed |
| cmpl_value | input | DATA_W | Result value or store data |
| cmpl_addr | input | DATA_W | Store address or resolved branch target |
| cmpl_taken | input | 1 | Resolved branch direction |
| cmpl_excp | input | 1 | Instruction faulted |
| lookup_idx | input | IDX_W | Slot probed by issue |
| lookup_hit | output | 1 | Probed slot is held and ready |
| lookup_value | output | DATA_W | Value of probed slot |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | REG_W | Register file write address |
| rf_wdata | output | DATA_W | Register file write data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | DATA_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| redirect_valid | output | 1 | Fetch must restart |
| redirect_pc | output | DATA_W | Restart target |
| excp_valid | output | 1 | Head faulted and was discarded |

## Verification
The slot index appears on `alloc_idx` in the cycle of the offer. A completion registered at one edge makes the slot ready, so a ready head shows its retire strobe during the cycle that starts at that edge, and the slot leaves at the next edge. A flush empties the buffer at the edge where the head retires, so the next accepted slot is the one after the offender. The bench drives inputs on falling edges and checks the returned index one time step later. A monitor samples the retire strobes shortly after each rising edge, so each retirement is logged exactly once. Ordering checks compare the log against the allocation order after enough idle cycles for every ready slot to drain.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_RSVD   = 2'd3
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             full
);
  logic [CNT_W-1:0] count_q;
  logic [IDX_W-1:0] head_q, tail_q;
  logic [IDX_W-1:0] head_inc;

  assign head_inc = head_q + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush) begin
      head_q  <= head_inc;
      tail_q  <= head_inc;
      count_q <= '0;
    end else begin
      if (pop)  head_q <= head_inc;
      if (push) tail_q <= tail_q + IDX_W'(1);
      case ({push, pop})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign full = (count_q == CNT_W'(DEPTH));

  // R2: occupancy never exceeds the slot count
  p_count_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  // R8 / R9: a flush leaves nothing held
  p_flush_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0));
  // R11: push and pop together keep the occupancy
  p_push_pop_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [1:0]        wr_kind,
  input  logic [REG_W-1:0]  wr_dest,
  input  logic              wr_pred,
  input  logic              done_en,
  input  logic [IDX_W-1:0]  done_slot,
  input  logic [DATA_W-1:0] done_value,
  input  logic [DATA_W-1:0] done_addr,
  input  logic              done_taken,
  input  logic              done_excp,
  input  logic              retire,
  input  logic              flush,
  input  logic [IDX_W-1:0]  head,
  input  logic [IDX_W-1:0]  probe_slot,
  output logic              hd_valid,
  output logic              hd_ready,
  output logic [1:0]        hd_kind,
  output logic [REG_W-1:0]  hd_dest,
  output logic              hd_pred,
  output logic [DATA_W-1:0] hd_value,
  output logic [DATA_W-1:0] hd_addr,
  output logic              hd_taken,
  output logic              hd_excp,
  output logic              probe_hit,
  output logic [DATA_W-1:0] probe_value
);
  logic              vld_q   [DEPTH];
  logic              rdy_q   [DEPTH];
  logic [1:0]        kind_q  [DEPTH];
  logic [REG_W-1:0]  dest_q  [DEPTH];
  logic              pred_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];
  logic [DATA_W-1:0] addr_q  [DEPTH];
  logic              taken_q [DEPTH];
  logic              excp_q  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic take_here, done_here;
    assign take_here = wr_en && (wr_slot == IDX_W'(e));
    assign done_here = done_en && (done_slot == IDX_W'(e)) && vld_q[e];

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        vld_q[e] <= 1'b0;
        rdy_q[e] <= 1'b0;
      end else if (take_here) begin
        vld_q[e] <= 1'b1;
        rdy_q[e] <= 1'b0;
      end else if (retire && (head == IDX_W'(e))) begin
        vld_q[e] <= 1'b0;
        rdy_q[e] <= 1'b0;
      end else if (done_here) begin
        rdy_q[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (take_here) begin
        kind_q[e] <= wr_kind;
        dest_q[e] <= wr_dest;
        pred_q[e] <= wr_pred;
      end
      if (done_here) begin
        value_q[e] <= done_value;
        addr_q[e]  <= done_addr;
        taken_q[e] <= done_taken;
        excp_q[e]  <= done_excp;
      end
    end

    // R3: completion of a held slot is visible as ready on the next cycle
    p_done_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_here && !flush && !(retire && head == IDX_W'(e))) |=> rdy_q[e]);
  end

  assign hd_valid    = vld_q[head];
  assign hd_ready    = rdy_q[head];
  assign hd_kind     = kind_q[head];
  assign hd_dest     = dest_q[head];
  assign hd_pred     = pred_q[head];
  assign hd_value    = value_q[head];
  assign hd_addr     = addr_q[head];
  assign hd_taken    = taken_q[head];
  assign hd_excp     = excp_q[head];
  assign probe_hit   = vld_q[probe_slot] && rdy_q[probe_slot];
  assign probe_value = value_q[probe_slot];
endmodule

// File: rtl/rob_retire_decode.sv
module rob_retire_decode #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              hd_valid,
  input  logic              hd_ready,
  input  logic [1:0]        hd_kind,
  input  logic [REG_W-1:0]  hd_dest,
  input  logic              hd_pred,
  input  logic [DATA_W-1:0] hd_value,
  input  logic [DATA_W-1:0] hd_addr,
  input  logic              hd_taken,
  input  logic              hd_excp,
  output logic              retire,
  output logic              flush,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_pc,
  output logic              excp_valid
);
  import rob_pkg::*;
  logic mispred;

  always_comb begin
    retire         = hd_valid && hd_ready;
    mispred        = (hd_kind == KIND_BRANCH) && (hd_taken != hd_pred);
    excp_valid     = retire && hd_excp;
    redirect_valid = retire && !hd_excp && mispred;
    flush          = excp_valid || redirect_valid;
    rf_we          = retire && !hd_excp && (hd_kind == KIND_REG);
    mem_we         = retire && !hd_excp && (hd_kind == KIND_STORE);
    rf_waddr       = hd_dest;
    rf_wdata       = hd_value;
    mem_addr       = hd_addr;
    mem_wdata      = hd_value;
    redirect_pc    = hd_addr;
  end
endmodule

// File: rtl/rob_commit_queue.sv
module rob_commit_queue #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              alloc_pred_taken,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              cmpl_valid,
  input  logic [IDX_W-1:0]  cmpl_idx,
  input  logic [DATA_W-1:0] cmpl_value,
  input  logic [DATA_W-1:0] cmpl_addr,
  input  logic              cmpl_taken,
  input  logic              cmpl_excp,
  input  logic [IDX_W-1:0]  lookup_idx,
  output logic              lookup_hit,
  output logic [DATA_W-1:0] lookup_value,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_pc,
  output logic              excp_valid
);
  logic [IDX_W-1:0]  head, tail;
  logic              full, retire, flush, take;
  logic              hd_valid, hd_ready, hd_pred, hd_taken, hd_excp;
  logic [1:0]        hd_kind;
  logic [REG_W-1:0]  hd_dest;
  logic [DATA_W-1:0] hd_value, hd_addr;

  assign alloc_ready = !full && !flush;
  assign take        = alloc_valid && alloc_ready;
  assign alloc_idx   = tail;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst_n(rst_n), .push(take), .pop(retire), .flush(flush),
    .head(head), .tail(tail), .full(full)
  );

  rob_entry_array #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) ent_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(take), .wr_slot(tail), .wr_kind(alloc_kind), .wr_dest(alloc_dest),
    .wr_pred(alloc_pred_taken),
    .done_en(cmpl_valid), .done_slot(cmpl_idx), .done_value(cmpl_value),
    .done_addr(cmpl_addr), .done_taken(cmpl_taken), .done_excp(cmpl_excp),
    .retire(retire), .flush(flush), .head(head), .probe_slot(lookup_idx),
    .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_kind(hd_kind),
    .hd_dest(hd_dest), .hd_pred(hd_pred), .hd_value(hd_value),
    .hd_addr(hd_addr), .hd_taken(hd_taken), .hd_excp(hd_excp),
    .probe_hit(lookup_hit), .probe_value(lookup_value)
  );

  rob_retire_decode #(.REG_W(REG_W), .DATA_W(DATA_W)) dec_i (
    .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_kind(hd_kind),
    .hd_dest(hd_dest), .hd_pred(hd_pred), .hd_value(hd_value),
    .hd_addr(hd_addr), .hd_taken(hd_taken), .hd_excp(hd_excp),
    .retire(retire), .flush(flush),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .excp_valid(excp_valid)
  );

  // R2: each accepted slot is followed by the next index
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_idx == $past(alloc_idx) + IDX_W'(1)));
  // R8: nothing younger than a mispredicted branch retires right after it
  p_redirect_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!rf_we && !mem_we && !redirect_valid && !excp_valid));
  // R9: a faulting head is followed by an empty buffer
  p_excp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    excp_valid |=> (!rf_we && !mem_we && !redirect_valid && !lookup_hit));
  // R6: a store retirement never touches the register file
  p_store_no_rf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && mem_we));
endmodule

// File: tb/rob_commit_queue_tb_top.sv
module rob_commit_queue_tb_top;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_ready, alloc_pred_taken = 1'b0;
  logic [1:0] alloc_kind = 2'd0;
  logic [4:0] alloc_dest = '0;
  logic [IDX_W-1:0] alloc_idx, cmpl_idx = '0, lookup_idx = '0;
  logic cmpl_valid = 1'b0, cmpl_taken = 1'b0, cmpl_excp = 1'b0;
  logic [31:0] cmpl_value = '0, cmpl_addr = '0;
  logic lookup_hit, rf_we, mem_we, redirect_valid, excp_valid;
  logic [31:0] lookup_value, rf_wdata, mem_addr, mem_wdata, redirect_pc;
  logic [4:0] rf_waddr;

  always #4 clk = ~clk;

  rob_commit_queue #(.DEPTH(DEPTH), .REG_W(5), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_kind(alloc_kind), .alloc_dest(alloc_dest), .alloc_pred_taken(alloc_pred_taken),
    .alloc_idx(alloc_idx), .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
    .cmpl_value(cmpl_value), .cmpl_addr(cmpl_addr), .cmpl_taken(cmpl_taken),
    .cmpl_excp(cmpl_excp), .lookup_idx(lookup_idx), .lookup_hit(lookup_hit),
    .lookup_value(lookup_value), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .excp_valid(excp_valid)
  );

  int n_chk = 0, n_fail = 0, exp_tail = 0;
  logic [IDX_W-1:0] last_idx;
  int rf_n = 0, mem_n = 0, rd_n = 0, ex_n = 0;
  logic [4:0]  rf_dest_log [256];
  logic [31:0] rf_val_log [256], mem_addr_log [256], mem_data_log [256], rd_log [256];

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (rf_we && rf_n < 256)   begin rf_dest_log[rf_n] = rf_waddr; rf_val_log[rf_n] = rf_wdata; rf_n++; end
      if (mem_we && mem_n < 256) begin mem_addr_log[mem_n] = mem_addr; mem_data_log[mem_n] = mem_wdata; mem_n++; end
      if (redirect_valid && rd_n < 256) begin rd_log[rd_n] = redirect_pc; rd_n++; end
      if (excp_valid) ex_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [1:0] k, input logic [4:0] d, input logic p, input string req);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_kind = k; alloc_dest = d; alloc_pred_taken = p;
    #1;
    chk(alloc_ready === 1'b1, {req, " alloc_ready"}, 32'(alloc_ready), 1);
    chk(alloc_idx === IDX_W'(exp_tail), {req, " alloc_idx"}, 32'(alloc_idx), 32'(exp_tail));
    last_idx = alloc_idx;
    @(posedge clk); #1;
    alloc_valid = 1'b0;
    exp_tail = (exp_tail + 1) % DEPTH;
  endtask

  task automatic do_cmpl(input logic [IDX_W-1:0] i, input logic [31:0] v, input logic [31:0] a,
                         input logic t, input logic x);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_idx = i; cmpl_value = v; cmpl_addr = a; cmpl_taken = t; cmpl_excp = x;
    @(posedge clk); #1;
    cmpl_valid = 1'b0; cmpl_excp = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [IDX_W-1:0] ia, ib, ic, id, base_idx;
    int base_rf, base_mem, base_rd, base_ex;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1: reset state
    chk(alloc_ready === 1'b1, "R1 ready", 32'(alloc_ready), 1);
    chk(alloc_idx === '0, "R1 idx", 32'(alloc_idx), 0);
    chk({rf_we, mem_we, redirect_valid, excp_valid, lookup_hit} === 5'b0, "R1 strobes",
        32'({rf_we, mem_we, redirect_valid, excp_valid, lookup_hit}), 0);

    // R4 / R5 / R2: fill, complete in permuted orders, expect program order
    for (int k = 1; k < 8; k += 2) begin
      base_rf = rf_n;
      base_idx = IDX_W'(exp_tail);
      for (int i = 0; i < DEPTH; i++) do_alloc(2'd0, 5'(((k * 3 + i) % 31) + 1), 1'b0, "R2");
      @(negedge clk); alloc_valid = 1'b1; #1;
      chk(alloc_ready === 1'b0, "R2 full", 32'(alloc_ready), 0);
      alloc_valid = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        int p;
        p = (j * k + 1) % DEPTH;
        do_cmpl(base_idx + IDX_W'(p), 32'h1000 * k + 32'(p * 17), 32'h0, 1'b0, 1'b0);
        if (k == 1 && j == DEPTH - 2) begin
          idle(2);
          chk(rf_n == base_rf, "R4 head unready blocks", 32'(rf_n), 32'(base_rf));
        end
      end
      idle(DEPTH + 3);
      chk(rf_n == base_rf + DEPTH, "R4 count", 32'(rf_n), 32'(base_rf + DEPTH));
      for (int i = 0; i < DEPTH; i++) begin
        chk(rf_dest_log[base_rf + i] == 5'(((k * 3 + i) % 31) + 1), "R4 order dest",
            32'(rf_dest_log[base_rf + i]), 32'(((k * 3 + i) % 31) + 1));
        chk(rf_val_log[base_rf + i] == 32'h1000 * k + 32'(i * 17), "R5 value",
            rf_val_log[base_rf + i], 32'h1000 * k + 32'(i * 17));
      end
    end

    // R3: completion to a slot not held is ignored
    base_rf = rf_n;
    do_cmpl(IDX_W'(exp_tail), 32'hDEAD, 32'h0, 1'b0, 1'b0);
    do_alloc(2'd0, 5'd7, 1'b0, "R3");
    ia = last_idx;
    idle(4);
    @(negedge clk); lookup_idx = ia; #1;
    chk(lookup_hit === 1'b0, "R3 stale completion", 32'(lookup_hit), 0);
    chk(rf_n == base_rf, "R3 no retire", 32'(rf_n), 32'(base_rf));
    do_cmpl(ia, 32'h77, 32'h0, 1'b0, 1'b0);
    idle(3);
    chk(rf_n == base_rf + 1 && rf_val_log[base_rf] == 32'h77, "R3 real completion",
        rf_val_log[base_rf], 32'h77);

    // R6: store retirement
    base_rf = rf_n; base_mem = mem_n;
    do_alloc(2'd1, 5'd0, 1'b0, "R6");
    do_cmpl(last_idx, 32'hBEEF, 32'h80, 1'b0, 1'b0);
    idle(3);
    chk(mem_n == base_mem + 1, "R6 mem count", 32'(mem_n), 32'(base_mem + 1));
    chk(mem_addr_log[base_mem] == 32'h80 && mem_data_log[base_mem] == 32'hBEEF, "R6 mem data",
        mem_data_log[base_mem], 32'hBEEF);
    chk(rf_n == base_rf, "R6 no rf", 32'(rf_n), 32'(base_rf));

    // R7: correct prediction
    base_rf = rf_n; base_rd = rd_n;
    do_alloc(2'd2, 5'd0, 1'b1, "R7"); ia = last_idx;
    do_alloc(2'd0, 5'd6, 1'b0, "R7"); ib = last_idx;
    do_cmpl(ib, 32'h66, 32'h0, 1'b0, 1'b0);
    do_cmpl(ia, 32'h0, 32'h500, 1'b1, 1'b0);
    idle(4);
    chk(rd_n == base_rd, "R7 no redirect", 32'(rd_n), 32'(base_rd));
    chk(rf_n == base_rf + 1 && rf_dest_log[base_rf] == 5'd6, "R7 follower retires",
        32'(rf_n - base_rf), 1);

    // R8 / R10: misprediction flush
    base_rf = rf_n; base_rd = rd_n; base_mem = mem_n;
    do_alloc(2'd0, 5'd2, 1'b0, "R8"); ia = last_idx;
    do_alloc(2'd2, 5'd0, 1'b0, "R8"); ib = last_idx;
    do_alloc(2'd0, 5'd3, 1'b0, "R8"); ic = last_idx;
    do_alloc(2'd1, 5'd0, 1'b0, "R8"); id = last_idx;
    do_cmpl(ic, 32'hCC, 32'h0, 1'b0, 1'b0);
    do_cmpl(id, 32'hDD, 32'h40, 1'b0, 1'b0);
    do_cmpl(ib, 32'h0, 32'h400, 1'b1, 1'b0);
    idle(2);
    chk(rf_n == base_rf, "R4 wait for head", 32'(rf_n), 32'(base_rf));
    @(negedge clk); lookup_idx = ic; #1;
    chk(lookup_hit === 1'b1 && lookup_value == 32'hCC, "R10 hit", lookup_value, 32'hCC);
    lookup_idx = ia; #1;
    chk(lookup_hit === 1'b0, "R10 miss unready", 32'(lookup_hit), 0);
    do_cmpl(ia, 32'hAA, 32'h0, 1'b0, 1'b0);
    idle(6);
    chk(rf_n == base_rf + 1 && rf_val_log[base_rf] == 32'hAA, "R8 older retires",
        32'(rf_n - base_rf), 1);
    chk(rd_n == base_rd + 1 && rd_log[base_rd] == 32'h400, "R8 redirect pc", rd_log[base_rd], 32'h400);
    chk(mem_n == base_mem, "R8 flushed store", 32'(mem_n), 32'(base_mem));
    @(negedge clk); lookup_idx = ic; #1;
    chk(lookup_hit === 1'b0, "R8 flushed lookup", 32'(lookup_hit), 0);
    exp_tail = (int'(ib) + 1) % DEPTH;
    do_alloc(2'd0, 5'd9, 1'b0, "R8 restart");
    do_cmpl(last_idx, 32'h99, 32'h0, 1'b0, 1'b0);
    idle(3);
    chk(rf_n == base_rf + 2 && rf_dest_log[base_rf + 1] == 5'd9, "R8 after flush",
        32'(rf_dest_log[base_rf + 1]), 9);

    // R9: exception at head
    base_rf = rf_n; base_ex = ex_n;
    do_alloc(2'd0, 5'd4, 1'b0, "R9"); ia = last_idx;
    do_alloc(2'd0, 5'd5, 1'b0, "R9"); ib = last_idx;
    do_cmpl(ib, 32'h55, 32'h0, 1'b0, 1'b0);
    do_cmpl(ia, 32'h44, 32'h0, 1'b0, 1'b1);
    idle(4);
    chk(ex_n == base_ex + 1, "R9 excp strobe", 32'(ex_n), 32'(base_ex + 1));
    chk(rf_n == base_rf, "R9 no writes", 32'(rf_n), 32'(base_rf));
    exp_tail = (int'(ia) + 1) % DEPTH;
    do_alloc(2'd0, 5'd8, 1'b0, "R9 restart");
    do_cmpl(last_idx, 32'h88, 32'h0, 1'b0, 1'b0);
    idle(3);
    chk(rf_n == base_rf + 1 && rf_val_log[base_rf] == 32'h88, "R9 after flush",
        rf_val_log[base_rf], 32'h88);

    // R11: allocation and retirement in the same cycle
    base_rf = rf_n;
    base_idx = IDX_W'(exp_tail);
    for (int i = 0; i < DEPTH - 1; i++) do_alloc(2'd0, 5'(i + 10), 1'b0, "R11");
    do_cmpl(base_idx, 32'h300, 32'h0, 1'b0, 1'b0);
    do_alloc(2'd0, 5'd20, 1'b0, "R11 same cycle");
    do_alloc(2'd0, 5'd21, 1'b0, "R11 room left");
    @(negedge clk); alloc_valid = 1'b1; #1;
    chk(alloc_ready === 1'b0, "R11 full again", 32'(alloc_ready), 0);
    alloc_valid = 1'b0;
    for (int i = 1; i <= DEPTH; i++) do_cmpl(base_idx + IDX_W'(i), 32'h300 + 32'(i), 32'h0, 1'b0, 1'b0);
    idle(DEPTH + 3);
    chk(rf_n == base_rf + DEPTH + 1, "R11 all retire", 32'(rf_n), 32'(base_rf + DEPTH + 1));
    chk(rf_dest_log[base_rf + DEPTH] == 5'd21, "R11 last dest", 32'(rf_dest_log[base_rf + DEPTH]), 21);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule